// File: doc/BRIEF.md
# Store Queue with Retired-Store Drain

The block keeps every store of a core in program order, from the moment dispatch allocates it until its write reaches the level-one cache. Dispatch takes a slot and gets back its index. The address and the data are written to that slot later, each through its own port and in either order. Retirement then names the oldest store that has not yet retired. The store is accepted only if both halves of it are present. An accepted store is senior: it can no longer be cancelled, but memory does not see it yet.

Senior stores leave from the oldest end, one per handshake, through a valid/ready write port toward the L1. A pipeline flush drops only the stores that have not retired. The allocation point snaps back to the retire boundary in one cycle. Senior stores stay in place and keep draining, so every retired store reaches the cache in the end.

The queue holds three wrapping pointers: allocation, retirement and commit. DEPTH must be a power of two.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `l1_valid` is 0 and the first allocation returns index 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` high at a clock edge, no `flush`) returns in `alloc_idx` the next index after the previous allocation, modulo DEPTH.
- R3: `alloc_ready` is 0 whenever DEPTH entries are held, counting both unretired and senior entries.
- R4: The address and the data of an allocated, unretired entry can be written in either order and in separate cycles. The values written are the ones later presented on the L1 port.
- R5: A retire request is accepted only when three conditions hold: `retire_idx` names the oldest unretired entry, both its address and its data were written, and an unretired entry exists. Any other request raises `retire_err` in the following cycle and changes no state.
- R6: Senior entries appear on `l1_addr`/`l1_data` with `l1_valid` high, oldest first. One entry leaves at each clock edge where `l1_valid` and `l1_ready` are both high.
- R7: While `l1_valid` is high and `l1_ready` is low, `l1_valid`, `l1_addr` and `l1_data` hold their values.
- R8: `flush` discards every unretired entry. The next allocation returns the index just after the newest senior entry, and a retire request issued before that allocation is rejected.
- R9: `flush` does not remove or alter senior entries. They stay on the L1 port and drain afterwards.
- R10: A retire request that is valid, in the same cycle as `flush`, is accepted before the discard. That entry becomes senior and drains.
- R11: Committing an entry frees its slot. `alloc_ready` rises after a commit from a full queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a new entry |
| alloc_ready | output | 1 | A free entry exists |
| alloc_idx | output | IW | Index given to the allocation |
| addr_wr_valid | input | 1 | Address write strobe |
| addr_wr_idx | input | IW | Entry receiving the address |
| addr_wr_val | input | AW | Store address |
| data_wr_valid | input | 1 | Data write strobe |
| data_wr_idx | input | IW | Entry receiving the data |
| data_wr_val | input | DW | Store data |
| retire_valid | input | 1 | Retire request |
| retire_idx | input | IW | Entry to retire |
| retire_err | output | 1 | Previous cycle's retire request was rejected |
| flush | input | 1 | Discard all unretired entries |
| l1_valid | output | 1 | A senior store is offered to the L1 |
| l1_ready | input | 1 | The L1 takes the offered store |
| l1_addr | output | AW | Address of the offered store |
| l1_data | output | DW | Data of the offered store |

## Verification
Properties are evaluated on every cycle. They cover the occupancy bound, the stability of the L1 payload under backpressure, the head advancing by one per commit, the tail landing on the retire boundary after a flush, and the survival of senior stores through a flush. Other behaviours show only in the bench's scenarios. These are the order and content of drained stores against a scoreboard, the index sequence after a flush, rejection of retires that are out of order, incomplete or empty, a retire issued together with a flush, and the freeing of a slot from a queue full of senior stores.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [2:0] {
    RC_IDLE,
    RC_OK,
    RC_EMPTY,
    RC_NOT_OLDEST,
    RC_INCOMPLETE
  } retire_chk_e;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alloc_valid,
  input  logic        retire_go,
  input  logic        flush,
  input  logic        l1_ready,
  output logic [IW:0] tail_q,
  output logic [IW:0] ret_q,
  output logic [IW:0] head_q,
  output logic        full,
  output logic        has_senior,
  output logic        alloc_fire,
  output logic        commit_fire
);
  localparam int PW = IW + 1;

  logic [PW-1:0] tail_d, ret_d, head_d;
  logic [PW-1:0] occ, senior_cnt;

  assign occ         = tail_q - head_q;
  assign senior_cnt  = ret_q - head_q;
  assign full        = (occ == PW'(DEPTH));
  assign has_senior  = (senior_cnt != '0);
  assign alloc_fire  = alloc_valid && !full && !flush;
  assign commit_fire = has_senior && l1_ready;

  always_comb begin
    ret_d  = ret_q + PW'(retire_go);
    head_d = head_q + PW'(commit_fire);
    if (flush) tail_d = ret_d;
    else       tail_d = tail_q + PW'(alloc_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      ret_q  <= '0;
      head_q <= '0;
    end else begin
      tail_q <= tail_d;
      ret_q  <= ret_d;
      head_q <= head_d;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= PW'(DEPTH));

  p_senior_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_q - head_q) <= (tail_q - head_q));

  p_commit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> head_q == $past(head_q) + PW'(1));

  p_flush_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tail_q == ret_q);
endmodule

// File: rtl/sq_entry_array.sv
module sq_entry_array #(
  parameter int DEPTH = 8,
  parameter int IW    = 3,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic [IW-1:0] alloc_idx,
  input  logic          addr_we,
  input  logic [IW-1:0] addr_idx,
  input  logic [AW-1:0] addr_in,
  input  logic          data_we,
  input  logic [IW-1:0] data_idx,
  input  logic [DW-1:0] data_in,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [IW-1:0] chk_idx,
  output logic          chk_has_addr,
  output logic          chk_has_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] has_a_q, has_d_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic has_a_d, has_d_d, a_en, d_en, clr;

    assign clr  = alloc_fire && (alloc_idx == IW'(g));
    assign a_en = addr_we && (addr_idx == IW'(g));
    assign d_en = data_we && (data_idx == IW'(g));

    always_comb begin
      has_a_d = has_a_q[g];
      has_d_d = has_d_q[g];
      if (clr) begin
        has_a_d = 1'b0;
        has_d_d = 1'b0;
      end
      if (a_en) has_a_d = 1'b1;
      if (d_en) has_d_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        has_a_q[g] <= 1'b0;
        has_d_q[g] <= 1'b0;
      end else begin
        has_a_q[g] <= has_a_d;
        has_d_q[g] <= has_d_d;
      end
    end

    always_ff @(posedge clk) begin
      if (a_en) addr_q[g] <= addr_in;
      if (d_en) data_q[g] <= data_in;
    end
  end

  assign rd_addr      = addr_q[rd_idx];
  assign rd_data      = data_q[rd_idx];
  assign chk_has_addr = has_a_q[chk_idx];
  assign chk_has_data = has_d_q[chk_idx];
endmodule

// File: rtl/sq_retire_gate.sv
module sq_retire_gate #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_valid,
  input  logic [IW-1:0] retire_idx,
  input  logic [IW:0]   ret_q,
  input  logic [IW:0]   tail_q,
  input  logic          has_addr,
  input  logic          has_data,
  output logic          retire_go,
  output logic          retire_err
);
  import sq_pkg::*;

  retire_chk_e chk;
  logic        err_d;

  always_comb begin
    if (!retire_valid)                     chk = RC_IDLE;
    else if (ret_q == tail_q)              chk = RC_EMPTY;
    else if (retire_idx != ret_q[IW-1:0])  chk = RC_NOT_OLDEST;
    else if (!(has_addr && has_data))      chk = RC_INCOMPLETE;
    else                                   chk = RC_OK;
  end

  assign retire_go = (chk == RC_OK);
  assign err_d     = (chk != RC_IDLE) && (chk != RC_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) retire_err <= 1'b0;
    else        retire_err <= err_d;
  end

  p_err_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_err |-> $past(retire_valid));
endmodule

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_idx,
  input  logic          addr_wr_valid,
  input  logic [IW-1:0] addr_wr_idx,
  input  logic [AW-1:0] addr_wr_val,
  input  logic          data_wr_valid,
  input  logic [IW-1:0] data_wr_idx,
  input  logic [DW-1:0] data_wr_val,
  input  logic          retire_valid,
  input  logic [IW-1:0] retire_idx,
  output logic          retire_err,
  input  logic          flush,
  output logic          l1_valid,
  input  logic          l1_ready,
  output logic [AW-1:0] l1_addr,
  output logic [DW-1:0] l1_data
);
  localparam int PW = IW + 1;

  logic [PW-1:0] tail_q, ret_q, head_q, spec_cnt;
  logic          full, has_senior, alloc_fire, commit_fire, retire_go;
  logic          chk_a, chk_d;
  logic [IW-1:0] a_off, d_off;
  logic          addr_we, data_we;

  sq_ptr_ctrl #(.DEPTH(DEPTH), .IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .retire_go(retire_go),
    .flush(flush), .l1_ready(l1_ready), .tail_q(tail_q), .ret_q(ret_q),
    .head_q(head_q), .full(full), .has_senior(has_senior),
    .alloc_fire(alloc_fire), .commit_fire(commit_fire)
  );

  // writes land only on live, unretired entries
  assign spec_cnt = tail_q - ret_q;
  assign a_off    = addr_wr_idx - ret_q[IW-1:0];
  assign d_off    = data_wr_idx - ret_q[IW-1:0];
  assign addr_we  = addr_wr_valid && !flush && ({1'b0, a_off} < spec_cnt);
  assign data_we  = data_wr_valid && !flush && ({1'b0, d_off} < spec_cnt);

  sq_entry_array #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_idx(tail_q[IW-1:0]),
    .addr_we(addr_we), .addr_idx(addr_wr_idx), .addr_in(addr_wr_val),
    .data_we(data_we), .data_idx(data_wr_idx), .data_in(data_wr_val),
    .rd_idx(head_q[IW-1:0]), .rd_addr(l1_addr), .rd_data(l1_data),
    .chk_idx(ret_q[IW-1:0]), .chk_has_addr(chk_a), .chk_has_data(chk_d)
  );

  sq_retire_gate #(.IW(IW)) u_gate (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_idx(retire_idx),
    .ret_q(ret_q), .tail_q(tail_q), .has_addr(chk_a), .has_data(chk_d),
    .retire_go(retire_go), .retire_err(retire_err)
  );

  assign alloc_ready = !full;
  assign alloc_idx   = tail_q[IW-1:0];
  assign l1_valid    = has_senior;

  p_l1_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    l1_valid && !l1_ready |=> l1_valid && $stable(l1_addr) && $stable(l1_data));

  p_senior_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush && l1_valid && !l1_ready |=> l1_valid);

  p_reject_no_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && !retire_go |=> ret_q == $past(ret_q));
endmodule

// File: tb/tb_store_queue.sv
module tb_store_queue;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic addr_wr_valid, data_wr_valid, retire_valid, retire_err, flush;
  logic [IW-1:0] addr_wr_idx, data_wr_idx, retire_idx;
  logic [AW-1:0] addr_wr_val, l1_addr;
  logic [DW-1:0] data_wr_val, l1_data;
  logic l1_valid, l1_ready;

  int total = 0, bad = 0, drained = 0, seq = 0, nxt = 0;
  logic [AW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [AW+DW-1:0] exp_q [$];

  always #5 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_alloc(string req);
    alloc_valid = 1'b1;
    @(negedge clk);
    chk(req, "alloc_ready", 64'(alloc_ready), 64'd1);
    chk(req, "alloc_idx", 64'(alloc_idx), 64'(nxt));
    step();
    alloc_valid = 1'b0;
    nxt = (nxt + 1) % DEPTH;
  endtask

  task automatic wr_addr(int idx);
    seq++;
    mem_a[idx] = AW'(32'h1000 + seq * 4);
    addr_wr_valid = 1'b1; addr_wr_idx = IW'(idx); addr_wr_val = mem_a[idx];
    step();
    addr_wr_valid = 1'b0;
  endtask

  task automatic wr_data(int idx);
    seq++;
    mem_d[idx] = DW'(32'hD000_0000 + seq);
    data_wr_valid = 1'b1; data_wr_idx = IW'(idx); data_wr_val = mem_d[idx];
    step();
    data_wr_valid = 1'b0;
  endtask

  // driver: pushes the expected drain item for every accepted retire
  task automatic do_retire(int idx, bit exp_err, bit with_flush, string req);
    if (!exp_err) exp_q.push_back({mem_a[idx], mem_d[idx]});
    retire_valid = 1'b1; retire_idx = IW'(idx); flush = with_flush;
    step();
    retire_valid = 1'b0; flush = 1'b0;
    @(negedge clk);
    chk(req, "retire_err", 64'(retire_err), 64'(exp_err));
    step();
  endtask

  // monitor: pops and compares each store taken by the L1 port
  always @(negedge clk) begin
    if (rst_n && l1_valid && l1_ready) begin
      if (exp_q.size() == 0) begin
        chk("R6", "unexpected drain", 64'(l1_addr), 64'd0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk("R6", "drain addr", 64'(l1_addr), 64'(e[AW+DW-1:DW]));
        chk("R4", "drain data", 64'(l1_data), 64'(e[DW-1:0]));
      end
      drained++;
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [AW-1:0] hold_a;
    logic [DW-1:0] hold_d;
    rst_n = 1'b0; alloc_valid = 0; addr_wr_valid = 0; data_wr_valid = 0;
    retire_valid = 0; flush = 0; l1_ready = 0;
    addr_wr_idx = '0; data_wr_idx = '0; retire_idx = '0;
    addr_wr_val = '0; data_wr_val = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R1", "l1_valid", 64'(l1_valid), 64'd0);
    chk("R1", "alloc_idx", 64'(alloc_idx), 64'd0);
    step();

    // R2 allocation order, R4 out-of-order fills
    for (int i = 0; i < 3; i++) do_alloc("R2");
    wr_data(2);
    wr_addr(0); wr_data(0); wr_addr(1); wr_data(1);

    // R5 rejections, then in-order accepts
    do_retire(1, 1'b1, 1'b0, "R5");
    do_retire(0, 1'b0, 1'b0, "R5");
    do_retire(1, 1'b0, 1'b0, "R5");
    do_retire(2, 1'b1, 1'b0, "R5");
    wr_addr(2);

    @(negedge clk);
    chk("R6", "l1_valid", 64'(l1_valid), 64'd1);
    chk("R6", "l1_addr oldest", 64'(l1_addr), 64'(mem_a[0]));
    hold_a = l1_addr; hold_d = l1_data;
    repeat (2) @(negedge clk);
    chk("R7", "held addr", 64'(l1_addr), 64'(hold_a));
    chk("R7", "held data", 64'(l1_data), 64'(hold_d));
    step();

    // R3 full with mixed senior and unretired entries
    for (int i = 0; i < 5; i++) do_alloc("R2");
    @(negedge clk);
    chk("R3", "alloc_ready full", 64'(alloc_ready), 64'd0);
    step();
    wr_addr(3);

    // R10 retire with flush, R8 discard, R9 senior kept
    do_retire(2, 1'b0, 1'b1, "R10");
    @(negedge clk);
    chk("R9", "l1_valid after flush", 64'(l1_valid), 64'd1);
    chk("R9", "l1_addr after flush", 64'(l1_addr), 64'(mem_a[0]));
    step();
    do_retire(3, 1'b1, 1'b0, "R8");
    nxt = 3;
    do_alloc("R8");

    l1_ready = 1'b1;
    for (int i = 0; i < 20 && drained < 3; i++) @(negedge clk);
    chk("R9", "drained count", 64'(drained), 64'd3);
    step();
    @(negedge clk);
    chk("R6", "l1_valid idle", 64'(l1_valid), 64'd0);
    step();
    l1_ready = 1'b0;

    // R3/R11 queue full of senior stores
    flush = 1'b1; step(); flush = 1'b0;
    nxt = 3;
    for (int i = 0; i < DEPTH; i++) do_alloc("R2");
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr((3 + i) % DEPTH); wr_data((3 + i) % DEPTH);
    end
    for (int i = 0; i < DEPTH; i++) do_retire((3 + i) % DEPTH, 1'b0, 1'b0, "R6");
    @(negedge clk);
    chk("R3", "alloc_ready senior full", 64'(alloc_ready), 64'd0);
    step();
    l1_ready = 1'b1;
    step();
    l1_ready = 1'b0;
    @(negedge clk);
    chk("R11", "alloc_ready after commit", 64'(alloc_ready), 64'd1);
    step();
    l1_ready = 1'b1;
    for (int i = 0; i < 40 && drained < 3 + DEPTH; i++) @(negedge clk);
    chk("R6", "total drained", 64'(drained), 64'(3 + DEPTH));
    chk("R6", "scoreboard empty", 64'(exp_q.size()), 64'd0);
    summary();
  end
endmodule